// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between a processor's interrupt-acknowledge pulse and a pair of eight-level interrupt controllers, one acting as master and one cascaded behind the master's level 2 input. When the acknowledge strobe arrives, it looks at the level each controller has chosen, its pending-request bits, its vector base and its end-of-interrupt options. From these it works out which 8-bit vector the processor must receive and which state updates each controller must make.

The update strobes are combinational in the acknowledge cycle, so each controller applies them at the same clock edge that ends that cycle. The vector is registered and presented in the following cycle, qualified by a one-cycle valid flag, and is held until the next acknowledge. The block also turns a rising interrupt from the slave into a latched request on the master's cascade input. That latch is released when the cascade level is acknowledged or when the slave is re-initialised. The controllers in the system this block serves reset their vector bases to 0x08 (master) and 0x70 (slave).

Top module: `cack_seq`

## Requirements
- R1: In every cycle with `ackStrobe` high, `intrDrop` and `mPendClr` are high in that same cycle.
- R2: If `mIrr` is zero at acknowledge, the vector is `mBase + 7` (spurious). No IRR-clear, ISR-set, pointer-load or slave strobe is raised, and `mIn2Level` keeps its value.
- R3: For an acknowledged level L, the IRR-clear strobe carries a one in bit L only, unless bit L of that controller's trigger-mode input is 1 (level mode), in which case it is zero.
- R4: For an acknowledged level L with auto-EOI off, the ISR-set strobe carries a one in bit L only. With auto-EOI on, ISR-set is zero, and the pointer-load strobe is raised with pointer value L exactly when rotate-on-auto-EOI is set.
- R5: For a non-spurious master level other than 2, the vector is `mBase + mLevel`, and no slave strobe is raised.
- R6: For master level 2 (non-spurious), `sPendClr` is raised and `mIn2Level` is low in the next cycle. If `sIrr` is zero, the vector is `sBase + 7` and no slave IRR, ISR or pointer strobe is raised.
- R7: For master level 2 with `sIrr` nonzero, the vector is `sBase + sLevel`, and the slave strobes follow R3 and R4 using `sLevel`.
- R8: A rising edge on `slaveInt` sets `mIn2Level` in the next cycle, with `mIn2Rise` high for exactly that one cycle. The latch stays set while no clear occurs.
- R9: A `slaveIcw1` pulse clears `mIn2Level` in the next cycle, and it wins over a rising `slaveInt` in the same cycle.
- R10: `vecValid` is high in exactly the cycle after each acknowledge. `vecOut` then carries the new vector and holds it until the next acknowledge.
- R11: `mReeval` is high in the cycle after every acknowledge. `sReeval` is high in that cycle only when the master level was 2 and `mIrr` was nonzero.
- R12: With `ackStrobe` low, every update strobe (`intrDrop`, both pending clears, IRR-clear, ISR-set, pointer-load) is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ackStrobe | input | 1 | Processor interrupt-acknowledge pulse |
| mIrr | input | 8 | Master pending-request bits |
| mLevel | input | 3 | Level the master has chosen |
| mBase | input | 8 | Master vector base |
| mTrigLevel | input | 8 | Master per-line trigger mode, 1 = level |
| mAutoEoi | input | 1 | Master auto-EOI enable |
| mRotAeoi | input | 1 | Master rotate-on-auto-EOI enable |
| sIrr | input | 8 | Slave pending-request bits |
| sLevel | input | 3 | Level the slave has chosen |
| sBase | input | 8 | Slave vector base |
| sTrigLevel | input | 8 | Slave per-line trigger mode, 1 = level |
| sAutoEoi | input | 1 | Slave auto-EOI enable |
| sRotAeoi | input | 1 | Slave rotate-on-auto-EOI enable |
| slaveInt | input | 1 | Slave interrupt output |
| slaveIcw1 | input | 1 | Slave first initialisation word written |
| intrDrop | output | 1 | Drop processor interrupt line |
| mPendClr | output | 1 | Clear master pending flag |
| mIrrClr | output | 8 | Master IRR bits to clear |
| mIsrSet | output | 8 | Master ISR bits to set |
| mPtrLoad | output | 1 | Load master lowest-priority pointer |
| mPtrVal | output | 3 | Value for master pointer |
| sPendClr | output | 1 | Clear slave pending flag |
| sIrrClr | output | 8 | Slave IRR bits to clear |
| sIsrSet | output | 8 | Slave ISR bits to set |
| sPtrLoad | output | 1 | Load slave lowest-priority pointer |
| sPtrVal | output | 3 | Value for slave pointer |
| mIn2Level | output | 1 | Latched state of master cascade input |
| mIn2Rise | output | 1 | One-cycle rising request on master cascade input |
| vecOut | output | 8 | Acknowledged vector |
| vecValid | output | 1 | Vector valid, cycle after acknowledge |
| mReeval | output | 1 | Master must re-evaluate |
| sReeval | output | 1 | Slave must re-evaluate |

## Verification
A wrong branch decision shows up at the ports in the acknowledge cycle itself. It appears as a strobe on the wrong controller, or a strobe present when the master had nothing pending. The wrong vector then shows in the very next cycle. A corrupted cascade latch shows one cycle after a slave edge, an initialisation write or a level-2 acknowledge: either the level or its one-cycle rise pulse is wrong. The bench mixes random acknowledge contexts, biased toward the cascade level and empty request sets, with directed latch sequences, and computes every expected value from the requirements.

// File: rtl/cack_pkg.sv
package cack_pkg;
  typedef enum logic [2:0] {
    VSEL_NONE,
    VSEL_MSPUR,
    VSEL_MLVL,
    VSEL_SSPUR,
    VSEL_SLVL
  } vecSel_e;

  typedef struct packed {
    vecSel_e vecSel;
    logic    casClr;
    logic    mReeval;
    logic    sReeval;
  } ackCtl_t;
endpackage

// File: rtl/cack_level_rule.sv
module cack_level_rule #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic               apply,
  input  logic [LVL_W-1:0]   level,
  input  logic [NUM_LVL-1:0] trigLevel,
  input  logic               autoEoi,
  input  logic               rotAeoi,
  output logic [NUM_LVL-1:0] irrClr,
  output logic [NUM_LVL-1:0] isrSet,
  output logic               ptrLoad,
  output logic [LVL_W-1:0]   ptrVal
);
  logic [NUM_LVL-1:0] lvlHot;

  always_comb begin
    lvlHot  = {{(NUM_LVL-1){1'b0}}, 1'b1} << level;
    irrClr  = (apply && !trigLevel[level]) ? lvlHot : '0;
    isrSet  = (apply && !autoEoi) ? lvlHot : '0;
    ptrLoad = apply && autoEoi && rotAeoi;
    ptrVal  = level;
  end
endmodule

// File: rtl/cack_ctrl.sv
module cack_ctrl
  import cack_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int CAS_LVL = 2,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic               ackStrobe,
  input  logic [NUM_LVL-1:0] mIrr,
  input  logic [LVL_W-1:0]   mLevel,
  input  logic [NUM_LVL-1:0] mTrigLevel,
  input  logic               mAutoEoi,
  input  logic               mRotAeoi,
  input  logic [NUM_LVL-1:0] sIrr,
  input  logic [LVL_W-1:0]   sLevel,
  input  logic [NUM_LVL-1:0] sTrigLevel,
  input  logic               sAutoEoi,
  input  logic               sRotAeoi,
  output logic               intrDrop,
  output logic               mPendClr,
  output logic [NUM_LVL-1:0] mIrrClr,
  output logic [NUM_LVL-1:0] mIsrSet,
  output logic               mPtrLoad,
  output logic [LVL_W-1:0]   mPtrVal,
  output logic               sPendClr,
  output logic [NUM_LVL-1:0] sIrrClr,
  output logic [NUM_LVL-1:0] sIsrSet,
  output logic               sPtrLoad,
  output logic [LVL_W-1:0]   sPtrVal,
  output ackCtl_t            ctl
);
  logic mSpur, mApply, isCascade, sPath, sSpur, sApply;

  always_comb begin
    mSpur     = ~|mIrr;
    mApply    = ackStrobe && !mSpur;
    isCascade = (mLevel == LVL_W'(CAS_LVL));
    sPath     = mApply && isCascade;
    sSpur     = ~|sIrr;
    sApply    = sPath && !sSpur;

    intrDrop  = ackStrobe;
    mPendClr  = ackStrobe;
    sPendClr  = sPath;

    ctl.casClr  = sPath;
    ctl.mReeval = ackStrobe;
    ctl.sReeval = sPath;
    if (!ackStrobe)      ctl.vecSel = VSEL_NONE;
    else if (mSpur)      ctl.vecSel = VSEL_MSPUR;
    else if (!isCascade) ctl.vecSel = VSEL_MLVL;
    else if (sSpur)      ctl.vecSel = VSEL_SSPUR;
    else                 ctl.vecSel = VSEL_SLVL;
  end

  cack_level_rule #(.NUM_LVL(NUM_LVL)) i_mRule (
    .apply(mApply), .level(mLevel), .trigLevel(mTrigLevel),
    .autoEoi(mAutoEoi), .rotAeoi(mRotAeoi),
    .irrClr(mIrrClr), .isrSet(mIsrSet), .ptrLoad(mPtrLoad), .ptrVal(mPtrVal)
  );

  cack_level_rule #(.NUM_LVL(NUM_LVL)) i_sRule (
    .apply(sApply), .level(sLevel), .trigLevel(sTrigLevel),
    .autoEoi(sAutoEoi), .rotAeoi(sRotAeoi),
    .irrClr(sIrrClr), .isrSet(sIsrSet), .ptrLoad(sPtrLoad), .ptrVal(sPtrVal)
  );
endmodule

// File: rtl/cack_dpath.sv
module cack_dpath
  import cack_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ackCtl_t          ctl,
  input  logic [VEC_W-1:0] mBase,
  input  logic [VEC_W-1:0] sBase,
  input  logic [LVL_W-1:0] mLevel,
  input  logic [LVL_W-1:0] sLevel,
  input  logic             slaveInt,
  input  logic             slaveIcw1,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid,
  output logic             mReeval,
  output logic             sReeval,
  output logic             mIn2Level,
  output logic             mIn2Rise
);
  localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'(NUM_LVL - 1);

  logic [VEC_W-1:0] vecNext;
  logic             slaveIntQ;
  logic             casRise, casClear;

  always_comb begin
    unique case (ctl.vecSel)
      VSEL_MSPUR: vecNext = mBase + SPUR_OFS;
      VSEL_MLVL:  vecNext = mBase + VEC_W'(mLevel);
      VSEL_SSPUR: vecNext = sBase + SPUR_OFS;
      VSEL_SLVL:  vecNext = sBase + VEC_W'(sLevel);
      default:    vecNext = vecOut;
    endcase
    casRise  = slaveInt && !slaveIntQ;
    casClear = ctl.casClr || slaveIcw1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut    <= '0;
      vecValid  <= 1'b0;
      mReeval   <= 1'b0;
      sReeval   <= 1'b0;
      slaveIntQ <= 1'b0;
      mIn2Level <= 1'b0;
      mIn2Rise  <= 1'b0;
    end else begin
      vecValid  <= (ctl.vecSel != VSEL_NONE);
      vecOut    <= vecNext;
      mReeval   <= ctl.mReeval;
      sReeval   <= ctl.sReeval;
      slaveIntQ <= slaveInt;
      if (casClear)     mIn2Level <= 1'b0;
      else if (casRise) mIn2Level <= 1'b1;
      mIn2Rise  <= casRise && !casClear && !mIn2Level;
    end
  end
endmodule

// File: rtl/cack_seq.sv
module cack_seq
  import cack_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int CAS_LVL = 2,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackStrobe,
  input  logic [NUM_LVL-1:0] mIrr,
  input  logic [LVL_W-1:0]   mLevel,
  input  logic [VEC_W-1:0]   mBase,
  input  logic [NUM_LVL-1:0] mTrigLevel,
  input  logic               mAutoEoi,
  input  logic               mRotAeoi,
  input  logic [NUM_LVL-1:0] sIrr,
  input  logic [LVL_W-1:0]   sLevel,
  input  logic [VEC_W-1:0]   sBase,
  input  logic [NUM_LVL-1:0] sTrigLevel,
  input  logic               sAutoEoi,
  input  logic               sRotAeoi,
  input  logic               slaveInt,
  input  logic               slaveIcw1,
  output logic               intrDrop,
  output logic               mPendClr,
  output logic [NUM_LVL-1:0] mIrrClr,
  output logic [NUM_LVL-1:0] mIsrSet,
  output logic               mPtrLoad,
  output logic [LVL_W-1:0]   mPtrVal,
  output logic               sPendClr,
  output logic [NUM_LVL-1:0] sIrrClr,
  output logic [NUM_LVL-1:0] sIsrSet,
  output logic               sPtrLoad,
  output logic [LVL_W-1:0]   sPtrVal,
  output logic               mIn2Level,
  output logic               mIn2Rise,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid,
  output logic               mReeval,
  output logic               sReeval
);
  ackCtl_t ctl;

  cack_ctrl #(.NUM_LVL(NUM_LVL), .CAS_LVL(CAS_LVL)) i_ctrl (
    .ackStrobe(ackStrobe),
    .mIrr(mIrr), .mLevel(mLevel), .mTrigLevel(mTrigLevel),
    .mAutoEoi(mAutoEoi), .mRotAeoi(mRotAeoi),
    .sIrr(sIrr), .sLevel(sLevel), .sTrigLevel(sTrigLevel),
    .sAutoEoi(sAutoEoi), .sRotAeoi(sRotAeoi),
    .intrDrop(intrDrop), .mPendClr(mPendClr),
    .mIrrClr(mIrrClr), .mIsrSet(mIsrSet), .mPtrLoad(mPtrLoad), .mPtrVal(mPtrVal),
    .sPendClr(sPendClr),
    .sIrrClr(sIrrClr), .sIsrSet(sIsrSet), .sPtrLoad(sPtrLoad), .sPtrVal(sPtrVal),
    .ctl(ctl)
  );

  cack_dpath #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .mBase(mBase), .sBase(sBase), .mLevel(mLevel), .sLevel(sLevel),
    .slaveInt(slaveInt), .slaveIcw1(slaveIcw1),
    .vecOut(vecOut), .vecValid(vecValid),
    .mReeval(mReeval), .sReeval(sReeval),
    .mIn2Level(mIn2Level), .mIn2Rise(mIn2Rise)
  );
endmodule

// File: rtl/cack_seq_chk.sv
module cack_seq_chk #(
  parameter int NUM_LVL = 8,
  parameter int CAS_LVL = 2,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ackStrobe,
  input logic [NUM_LVL-1:0] mIrr,
  input logic [LVL_W-1:0]   mLevel,
  input logic [VEC_W-1:0]   mBase,
  input logic               mAutoEoi,
  input logic               slaveIcw1,
  input logic               intrDrop,
  input logic               mPendClr,
  input logic [NUM_LVL-1:0] mIrrClr,
  input logic [NUM_LVL-1:0] mIsrSet,
  input logic               mPtrLoad,
  input logic               sPendClr,
  input logic [NUM_LVL-1:0] sIrrClr,
  input logic [NUM_LVL-1:0] sIsrSet,
  input logic               sPtrLoad,
  input logic               mIn2Level,
  input logic               mIn2Rise,
  input logic [VEC_W-1:0]   vecOut,
  input logic               vecValid,
  input logic               mReeval,
  input logic               sReeval
);
  logic noSlaveStrobe;
  assign noSlaveStrobe = !sPendClr && (sIrrClr == '0) && (sIsrSet == '0) && !sPtrLoad;

  assert_ack_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |-> intrDrop && mPendClr);

  assert_spur_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr == '0) |-> (mIrrClr == '0) && (mIsrSet == '0) && !mPtrLoad && noSlaveStrobe);

  assert_spur_vec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr == '0) |=> vecOut == $past(mBase) + VEC_W'(NUM_LVL - 1));

  assert_isr_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mIsrSet) && $onehot0(sIsrSet));

  assert_aeoi_no_isr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr != '0 && mAutoEoi) |-> mIsrSet == '0);

  assert_noncas_slave_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr != '0 && mLevel != LVL_W'(CAS_LVL)) |-> noSlaveStrobe);

  assert_cas_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr != '0 && mLevel == LVL_W'(CAS_LVL)) |=> !mIn2Level);

  assert_rise_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    mIn2Rise |-> mIn2Level);

  assert_icw1_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    slaveIcw1 |=> !mIn2Level);

  assert_valid_after_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> vecValid);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !vecValid && $stable(vecOut));

  assert_reeval_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && mIrr != '0 && mLevel == LVL_W'(CAS_LVL)) |=> mReeval && sReeval);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |-> !intrDrop && !mPendClr && (mIrrClr == '0) && (mIsrSet == '0) && !mPtrLoad && noSlaveStrobe);
endmodule

bind cack_seq cack_seq_chk #(.NUM_LVL(NUM_LVL), .CAS_LVL(CAS_LVL), .VEC_W(VEC_W)) i_cack_seq_chk (.*);

// File: tb/test_cack_seq.sv
module test_cack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TRIALS     = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackStrobe = 1'b0;
  logic [7:0] mIrr = '0, mBase = 8'h08, mTrigLevel = '0;
  logic [2:0] mLevel = '0;
  logic       mAutoEoi = 1'b0, mRotAeoi = 1'b0;
  logic [7:0] sIrr = '0, sBase = 8'h70, sTrigLevel = '0;
  logic [2:0] sLevel = '0;
  logic       sAutoEoi = 1'b0, sRotAeoi = 1'b0;
  logic       slaveInt = 1'b0, slaveIcw1 = 1'b0;

  logic       intrDrop, mPendClr, mPtrLoad, sPendClr, sPtrLoad;
  logic [7:0] mIrrClr, mIsrSet, sIrrClr, sIsrSet, vecOut;
  logic [2:0] mPtrVal, sPtrVal;
  logic       mIn2Level, mIn2Rise, vecValid, mReeval, sReeval;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cack_seq i_cack_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expIrrClr(input bit apply, input logic [2:0] lvl, input logic [7:0] trig);
    logic [7:0] r = '0;
    if (apply && trig[lvl] == 1'b0) r[lvl] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] expIsrSet(input bit apply, input logic [2:0] lvl, input bit aeoi);
    logic [7:0] r = '0;
    if (apply && !aeoi) r[lvl] = 1'b1;
    return r;
  endfunction

  task automatic checkIdle(input string tag);
    check(!intrDrop && !mPendClr && !sPendClr && !mPtrLoad && !sPtrLoad &&
          mIrrClr == 0 && mIsrSet == 0 && sIrrClr == 0 && sIsrSet == 0,
          {"R12 ", tag}, {intrDrop, mPendClr, sPendClr, mPtrLoad, sPtrLoad}, 0);
  endtask

  // one acknowledge with the current context; called right after a negedge
  task automatic doAck();
    bit mSpur, mApply, cas, sPath, sSpur, sApply;
    logic [7:0] eVec;
    string vTag;
    mSpur  = (mIrr == 0);
    mApply = !mSpur;
    cas    = (mLevel == 3'd2);
    sPath  = mApply && cas;
    sSpur  = (sIrr == 0);
    sApply = sPath && !sSpur;
    if (mSpur)     begin eVec = mBase + 8'd7;            vTag = "R2 vector"; end
    else if (!cas) begin eVec = mBase + {5'd0, mLevel};  vTag = "R5 vector"; end
    else if (sSpur) begin eVec = sBase + 8'd7;           vTag = "R6 vector"; end
    else           begin eVec = sBase + {5'd0, sLevel};  vTag = "R7 vector"; end

    ackStrobe = 1'b1;
    #1;
    check(intrDrop && mPendClr, "R1 drop/pending", {intrDrop, mPendClr}, 2'b11);
    check(mIrrClr == expIrrClr(mApply, mLevel, mTrigLevel), "R3 master irrClr", mIrrClr, expIrrClr(mApply, mLevel, mTrigLevel));
    check(mIsrSet == expIsrSet(mApply, mLevel, mAutoEoi), "R4 master isrSet", mIsrSet, expIsrSet(mApply, mLevel, mAutoEoi));
    check(mPtrLoad == (mApply && mAutoEoi && mRotAeoi), "R4 master ptrLoad", mPtrLoad, mApply && mAutoEoi && mRotAeoi);
    if (mPtrLoad) check(mPtrVal == mLevel, "R4 master ptrVal", mPtrVal, mLevel);
    check(sPendClr == sPath, "R6 sPendClr", sPendClr, sPath);
    check(sIrrClr == expIrrClr(sApply, sLevel, sTrigLevel), "R7 slave irrClr", sIrrClr, expIrrClr(sApply, sLevel, sTrigLevel));
    check(sIsrSet == expIsrSet(sApply, sLevel, sAutoEoi), "R7 slave isrSet", sIsrSet, expIsrSet(sApply, sLevel, sAutoEoi));
    check(sPtrLoad == (sApply && sAutoEoi && sRotAeoi), "R7 slave ptrLoad", sPtrLoad, sApply && sAutoEoi && sRotAeoi);
    if (sPtrLoad) check(sPtrVal == sLevel, "R7 slave ptrVal", sPtrVal, sLevel);
    @(negedge clk);
    ackStrobe = 1'b0;
    #1;
    check(vecValid == 1'b1, "R10 valid after ack", vecValid, 1);
    check(vecOut == eVec, vTag, vecOut, eVec);
    check(mReeval == 1'b1, "R11 mReeval", mReeval, 1);
    check(sReeval == sPath, "R11 sReeval", sReeval, sPath);
    if (sPath) check(mIn2Level == 1'b0, "R6 cascade latch cleared", mIn2Level, 0);
    checkIdle("after ack");
    @(negedge clk);
    #1;
    check(vecValid == 1'b0 && vecOut == eVec, "R10 hold", {vecValid, vecOut}, {1'b0, eVec});
    check(mReeval == 1'b0 && sReeval == 1'b0, "R11 reeval one cycle", {mReeval, sReeval}, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!vecValid && vecOut == 0 && !mIn2Level && !mIn2Rise && !mReeval && !sReeval,
          "R10 reset state", {vecValid, vecOut, mIn2Level, mIn2Rise}, 0);
    checkIdle("reset");

    // directed: default bases, master level 5, edge, normal EOI
    @(negedge clk);
    mIrr = 8'h20; mLevel = 3'd5; doAck();
    // spurious master
    mIrr = 8'h00; doAck();
    // level-mode line, auto-EOI with rotate
    mIrr = 8'h08; mLevel = 3'd3; mTrigLevel = 8'h08; mAutoEoi = 1'b1; mRotAeoi = 1'b1; doAck();
    // cascade, slave spurious
    mTrigLevel = '0; mAutoEoi = 1'b0; mRotAeoi = 1'b0;
    mIrr = 8'h04; mLevel = 3'd2; sIrr = 8'h00; doAck();
    // cascade, slave level 6, slave auto-EOI rotate
    sIrr = 8'h40; sLevel = 3'd6; sAutoEoi = 1'b1; sRotAeoi = 1'b1; doAck();

    // cascade latch: rising slaveInt
    slaveInt = 1'b1;
    @(negedge clk); #1;
    check(mIn2Level && mIn2Rise, "R8 rise sets latch and pulse", {mIn2Level, mIn2Rise}, 2'b11);
    @(negedge clk); #1;
    check(mIn2Level && !mIn2Rise, "R8 pulse one cycle, latch holds", {mIn2Level, mIn2Rise}, 2'b10);
    // cascade ack clears it; held slaveInt is no new edge
    sAutoEoi = 1'b0; sRotAeoi = 1'b0;
    doAck();
    check(!mIn2Level, "R6 latch stays clear without new edge", mIn2Level, 0);
    // a non-cascade ack leaves the latch alone
    slaveInt = 1'b0;
    @(negedge clk);
    slaveInt = 1'b1;
    @(negedge clk); #1;
    check(mIn2Level, "R8 second rise sets latch", mIn2Level, 1);
    mIrr = 8'h02; mLevel = 3'd1; doAck();
    check(mIn2Level, "R5 non-cascade ack keeps latch", mIn2Level, 1);
    mIrr = 8'h00; mLevel = 3'd2; doAck();
    check(mIn2Level, "R2 spurious ack keeps latch", mIn2Level, 1);
    // initialisation write clears latch
    slaveIcw1 = 1'b1;
    @(negedge clk); #1;
    slaveIcw1 = 1'b0;
    check(!mIn2Level, "R9 icw1 clears latch", mIn2Level, 0);
    // clear wins over a simultaneous rising edge
    slaveInt = 1'b0;
    @(negedge clk);
    slaveInt = 1'b1; slaveIcw1 = 1'b1;
    @(negedge clk); #1;
    slaveIcw1 = 1'b0;
    check(!mIn2Level && !mIn2Rise, "R9 clear wins over rise", {mIn2Level, mIn2Rise}, 0);
    @(negedge clk); #1;
    checkIdle("idle");
    slaveInt = 1'b0;

    // constrained random acknowledge contexts
    for (int t = 0; t < TRIALS; t++) begin
      mIrr       = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      mLevel     = ($urandom_range(0, 2) == 0) ? 3'd2 : 3'($urandom);
      mBase      = (t < 20) ? 8'h08 : {5'($urandom), 3'b000};
      mTrigLevel = 8'($urandom);
      mAutoEoi   = 1'($urandom);
      mRotAeoi   = 1'($urandom);
      sIrr       = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      sLevel     = 3'($urandom);
      sBase      = (t < 20) ? 8'h70 : {5'($urandom), 3'b000};
      sTrigLevel = 8'($urandom);
      sAutoEoi   = 1'($urandom);
      sRotAeoi   = 1'($urandom);
      doAck();
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); #1;
        checkIdle("random gap");
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule